// File: doc/BRIEF.md
# System Clock Mode Controller

This block holds the processor's clock and mode control byte and turns it into a system-clock enable. Three clock sources reach it as tick inputs: a main crystal oscillator, a slow sub oscillator and a free-running on-chip ring oscillator. All three are sampled in one fast reference clock domain. A rising edge on the selected tick advances a divider. Each time that divider reaches its terminal count, the block emits a one-cycle `sys_ce` pulse. Logic downstream uses `sys_ce` as its clock enable.

The control byte is reached over a byte-wide register bus at one address. It also drives the main and sub oscillator enables, the stack-page select and the processor-mode field. After reset the system runs from the on-chip oscillator, and both external oscillators are stopped. Software must first start an oscillator, wait for it to settle while running from the ring, and only then switch over. A write that moves the source-select bit in the same write as either of two neighbouring bits is refused, and a sticky error flag is raised.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the control byte reads 0x68. `main_osc_en` is 0, `sub_osc_en` is 0, `stack_page` is 0 and `proc_mode` is 0.
- R2: A bus write with `bus_sel`=1 and `bus_addr`=0x3B stores `bus_wdata`, and a read at that address returns the stored byte. Writes to any other address leave the byte unchanged, and reads at any other address return 0.
- R3: A write is refused and the byte is left unchanged if, compared with the current value, it flips both bit 7 and bit 3, or both bit 7 and bit 6. Such a write sets `wr_err` to 1 on the next cycle.
- R4: `wr_err` stays set until a read at 0x3B occurs. After that read it is 0, unless a refused write happens in the same cycle.
- R5: When bit 7 is 0 and bit 3 is 1, one `sys_ce` pulse is produced for every 32 rising edges of `ring_tick`. Bit 6 has no effect in this mode.
- R6: When bits 7, 6 and 3 are all 0 and bit 5 is 0, one `sys_ce` pulse is produced for every 2 rising edges of `main_tick`.
- R7: When bit 7 is 0, bit 6 is 1, bit 3 is 0 and bit 5 is 0, one `sys_ce` pulse is produced for every 8 rising edges of `main_tick`.
- R8: When bit 7 is 1 and bit 4 is 1, each rising edge of `sub_tick` produces one `sys_ce` pulse.
- R9: Edges on a stopped oscillator's tick never count. This covers `main_tick` when bit 5 is 1 and `sub_tick` when bit 4 is 0. Ticks on sources that are not selected produce no pulse either.
- R10: The divider restarts from zero whenever the selected source or ratio changes.
- R11: `main_osc_en` equals the inverse of bit 5, `sub_osc_en` equals bit 4, `stack_page` equals bit 2 and `proc_mode` equals bits 1:0. All four processor-mode codes are stored and read back.
- R12: Every `sys_ce` pulse lasts exactly one reference clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 unless the address hits |
| main_tick | input | 1 | Main oscillator square wave |
| sub_tick | input | 1 | Sub oscillator square wave |
| ring_tick | input | 1 | On-chip oscillator square wave |
| sys_ce | output | 1 | One-cycle system clock enable |
| main_osc_en | output | 1 | Main oscillator run control |
| sub_osc_en | output | 1 | Sub oscillator pin/run control |
| stack_page | output | 1 | Stack page select |
| proc_mode | output | 2 | Processor mode field |
| wr_err | output | 1 | Sticky refused-write flag |

## Verification
The assertions assume two things about the tick inputs. Each tick stays high and low for longer than the synchroniser depth, so two rising edges of one source never fall in adjacent cycles, and no tick edge is in flight while the selection changes. The bench drives every tick as a square wave held four reference cycles in each phase. It changes the control byte only while all ticks are idle, and it waits for the divider restart before it sends new edges.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int          CTRL_W        = 8;
  localparam int          BIT_STACK     = 2;
  localparam int          BIT_RING_SEL  = 3;
  localparam int          BIT_SUB_EN    = 4;
  localparam int          BIT_MAIN_STOP = 5;
  localparam int          BIT_MAIN_SLOW = 6;
  localparam int          BIT_SYS_SUB   = 7;
  localparam logic [7:0]  CTRL_RESET    = 8'h68;

  typedef enum logic [1:0] {
    SRC_MAIN_FAST = 2'd0,
    SRC_MAIN_SLOW = 2'd1,
    SRC_RING      = 2'd2,
    SRC_SUB       = 2'd3
  } clk_src_e;
endpackage

// File: rtl/sysclk_rst_sync.sv
module sysclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysclk_mode_reg.sv
module sysclk_mode_reg
  import sysclk_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h3B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic [CTRL_W-1:0] mode_q,
  output logic              wr_err
);
  logic [CTRL_W-1:0] mode_d;
  logic [CTRL_W-1:0] flip;
  logic              hit, bad_pair, wr_ok, wr_bad, err_d;

  always_comb begin
    hit      = bus_sel && (bus_addr == ADDR_W'(REG_ADDR));
    flip     = bus_wdata ^ mode_q;
    bad_pair = (flip[BIT_SYS_SUB] && flip[BIT_RING_SEL]) ||
               (flip[BIT_SYS_SUB] && flip[BIT_MAIN_SLOW]);
    wr_ok    = hit && bus_wr && !bad_pair;
    wr_bad   = hit && bus_wr && bad_pair;
    mode_d   = wr_ok ? bus_wdata : mode_q;
    if (wr_bad)                err_d = 1'b1;
    else if (hit && bus_rd)    err_d = 1'b0;
    else                       err_d = wr_err;
    bus_rdata = (hit && bus_rd) ? mode_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CTRL_RESET;
      wr_err <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wr_err <= err_d;
    end
  end
endmodule

// File: rtl/sysclk_tick_edge.sv
module sysclk_tick_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic run,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   synced;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= tick_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], tick_in};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= synced;
  end

  assign rise = run && synced && !last_q;
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] term,
  output logic             ce
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ce_d;

  always_comb begin
    cnt_d = cnt_q;
    ce_d  = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      if (cnt_q >= term) begin
        cnt_d = '0;
        ce_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ce    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ce    <= ce_d;
    end
  end
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int         ADDR_W        = 8,
  parameter logic [7:0] REG_ADDR      = 8'h3B,
  parameter int         DIV_MAIN_FAST = 2,
  parameter int         DIV_MAIN_SLOW = 8,
  parameter int         DIV_RING      = 32,
  parameter int         DIV_SUB       = 1,
  parameter int         SYNC_STAGES   = 2,
  parameter int         RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              ring_tick,
  output logic              sys_ce,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic              stack_page,
  output logic [1:0]        proc_mode,
  output logic              wr_err
);
  localparam int NUM_SRC = 3;
  localparam int DIV_MAX = (DIV_RING > DIV_MAIN_SLOW) ? DIV_RING : DIV_MAIN_SLOW;
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam int IDX_MAIN = 0;
  localparam int IDX_RING = 1;
  localparam int IDX_SUB  = 2;

  logic               rst_sync_n;
  logic [7:0]         mode_q;
  logic [NUM_SRC-1:0] tick_vec, run_vec, rise_vec;
  clk_src_e           src_sel, src_q;
  logic               step, clear;
  logic [CNT_W-1:0]   term;

  sysclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sysclk_mode_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_q(mode_q), .wr_err(wr_err)
  );

  assign tick_vec = {sub_tick, ring_tick, main_tick};
  assign run_vec  = {mode_q[BIT_SUB_EN], 1'b1, !mode_q[BIT_MAIN_STOP]};

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      sysclk_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_sync_n),
        .tick_in(tick_vec[i]), .run(run_vec[i]), .rise(rise_vec[i])
      );
    end
  endgenerate

  always_comb begin
    if (mode_q[BIT_SYS_SUB])        src_sel = SRC_SUB;
    else if (mode_q[BIT_RING_SEL])  src_sel = SRC_RING;
    else if (mode_q[BIT_MAIN_SLOW]) src_sel = SRC_MAIN_SLOW;
    else                            src_sel = SRC_MAIN_FAST;
    case (src_sel)
      SRC_MAIN_FAST: begin step = rise_vec[IDX_MAIN]; term = CNT_W'(DIV_MAIN_FAST - 1); end
      SRC_MAIN_SLOW: begin step = rise_vec[IDX_MAIN]; term = CNT_W'(DIV_MAIN_SLOW - 1); end
      SRC_RING:      begin step = rise_vec[IDX_RING]; term = CNT_W'(DIV_RING - 1);      end
      default:       begin step = rise_vec[IDX_SUB];  term = CNT_W'(DIV_SUB - 1);       end
    endcase
    clear = (src_sel != src_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) src_q <= SRC_RING;
    else             src_q <= src_sel;
  end

  sysclk_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n),
    .step(step), .clear(clear), .term(term), .ce(sys_ce)
  );

  assign main_osc_en = !mode_q[BIT_MAIN_STOP];
  assign sub_osc_en  = mode_q[BIT_SUB_EN];
  assign stack_page  = mode_q[BIT_STACK];
  assign proc_mode   = mode_q[1:0];
endmodule

// File: rtl/sysclk_mode_ctrl_chk.sv
module sysclk_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] mode_q,
  input logic       wr_err,
  input logic       sys_ce
);
  logic hit, bad;
  assign hit = bus_sel && (bus_addr == 8'h3B);
  assign bad = ((bus_wdata[7] ^ mode_q[7]) && (bus_wdata[3] ^ mode_q[3])) ||
               ((bus_wdata[7] ^ mode_q[7]) && (bus_wdata[6] ^ mode_q[6]));

  assert_refused_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wr && bad) |=> $stable(mode_q));

  assert_refused_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wr && bad) |=> wr_err);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_rd && !(bus_wr && bad)) |=> !wr_err);

  assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> $stable(mode_q));

  assert_sub_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[7] && !mode_q[4]) |=> !sys_ce);

  assert_main_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[7] && !mode_q[3] && mode_q[5]) |=> !sys_ce);

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |=> !sys_ce);
endmodule

bind sysclk_mode_ctrl sysclk_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mode_q(mode_q), .wr_err(wr_err), .sys_ce(sys_ce)
);

// File: tb/sysclk_mode_ctrl_tb.sv
module sysclk_mode_ctrl_tb;
  logic       clk, rst_n;
  logic       bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       main_tick, sub_tick, ring_tick;
  logic       sys_ce, main_osc_en, sub_osc_en, stack_page, wr_err;
  logic [1:0] proc_mode;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int wide   = 0;
  logic ce_prev = 1'b0;
  logic done = 1'b0;

  sysclk_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .main_tick(main_tick), .sub_tick(sub_tick), .ring_tick(ring_tick),
    .sys_ce(sys_ce), .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
    .stack_page(stack_page), .proc_mode(proc_mode), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (sys_ce) pulses++;
    if (sys_ce && ce_prev) wide++;
    ce_prev = sys_ce;
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    idle(3);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // which: 0 main, 1 ring, 2 sub
  task automatic tick(input int which);
    @(negedge clk);
    case (which)
      0: main_tick = 1'b1;
      1: ring_tick = 1'b1;
      default: sub_tick = 1'b1;
    endcase
    idle(4);
    main_tick = 1'b0; ring_tick = 1'b0; sub_tick = 1'b0;
    idle(3);
  endtask

  // Count pulses over n edges; expected floor(k/div) after each edge
  task automatic sweep(input int which, input int n, input int div, input string req);
    int base;
    base = pulses;
    for (int k = 1; k <= n; k++) begin
      tick(which);
      check(pulses - base, (div == 0) ? 0 : k / div, req);
    end
  endtask

  initial begin
    logic [7:0] v;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    main_tick = 0; sub_tick = 0; ring_tick = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd(8'h3B, v);  check(v, 8'h68, "R1 reset value");
    check(main_osc_en, 0, "R1 main_osc_en");
    check(sub_osc_en, 0, "R1 sub_osc_en");
    check(stack_page, 0, "R1 stack_page");
    check(proc_mode, 0, "R1 proc_mode");
    check(wr_err, 0, "R1 wr_err");

    // R5 ring /32 at reset config (bit6=1 ignored)
    sweep(1, 70, 32, "R5 ring bit6=1");
    sweep(0, 10, 0, "R9 main stopped");
    sweep(2, 4, 0, "R9 sub unselected");

    // R2 other address ignored, reads 0
    wr(8'h3A, 8'h00);
    rd(8'h3B, v);  check(v, 8'h68, "R2 other addr write");
    rd(8'h3C, v);  check(v, 8'h00, "R2 other addr read");

    // R11 processor-mode codes and stack page
    for (int m = 0; m < 4; m++) begin
      wr(8'h3B, 8'h6C | 8'(m));
      rd(8'h3B, v);  check(v, 8'h6C | m, "R11 readback");
      check(proc_mode, m, "R11 proc_mode");
      check(stack_page, 1, "R11 stack_page");
    end
    wr(8'h3B, 8'h68);

    // start main, stay on ring
    wr(8'h3B, 8'h48);
    check(main_osc_en, 1, "R11 main_osc_en");
    // R7 main /8
    wr(8'h3B, 8'h40);
    sweep(0, 40, 8, "R7 main div8");
    sweep(1, 40, 0, "R9 ring unselected");
    // R10 restart: 5 edges in /8, switch to /2
    wr(8'h3B, 8'h48);
    wr(8'h3B, 8'h40);
    sweep(0, 5, 8, "R10 partial");
    wr(8'h3B, 8'h00);
    sweep(0, 20, 2, "R6 main div2 R10 restart");

    // R3 bits 6 and 7 together refused
    wr(8'h3B, 8'hC0);
    check(wr_err, 1, "R3 err 6/7");
    rd(8'h3B, v);  check(v, 8'h00, "R3 kept 6/7");
    idle(1);
    check(wr_err, 0, "R4 read clears");
    // sticky: another legal write keeps flag clear, refused sets and stays
    wr(8'h3B, 8'h88);
    check(wr_err, 1, "R3 err 3/7");
    wr(8'h3B, 8'h01);
    check(wr_err, 1, "R4 sticky");
    rd(8'h3B, v);  check(v, 8'h01, "R3 legal after refuse");
    idle(1);
    check(wr_err, 0, "R4 cleared");
    wr(8'h3B, 8'h00);

    // R9 main stopped while selected
    wr(8'h3B, 8'h20);
    check(main_osc_en, 0, "R11 main stopped");
    sweep(0, 10, 0, "R9 main stopped selected");
    wr(8'h3B, 8'h00);

    // R9 sub selected but stopped
    wr(8'h3B, 8'h80);
    sweep(2, 6, 0, "R9 sub stopped");
    // R8 sub running
    wr(8'h3B, 8'h90);
    check(sub_osc_en, 1, "R11 sub_osc_en");
    sweep(2, 12, 1, "R8 sub direct");

    // R5 ring with bit6=0
    wr(8'h3B, 8'h10);
    wr(8'h3B, 8'h18);
    sweep(1, 66, 32, "R5 ring bit6=0");

    check(wide, 0, "R12 single-cycle pulse");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule